// File: doc/BRIEF.md
# Priority Flow Control Pause Timers

This block turns decoded priority flow control requests into per-class transmit stalls. Each of the eight priority classes has its own countdown timer, measured in pause quanta, and its own pause flag. The frame receiver presents a decoded request as a single-cycle strobe. Alongside the strobe come an 8-bit class-enable vector and eight 16-bit quanta fields. Class n occupies bits [16n+15:16n] of the packed quanta bus. A shared tick input marks each quantum of 512 bit times. Each class timer counts down on that tick.

Every transmit queue also has a small gate. The gate turns the class pause flag into a block signal for the transmit scheduler. If the pause arrives while a frame from that queue is in flight, the gate lets the frame finish. The queue is blocked only after its end-of-packet.

The timer of each class is a two-state machine: IDLE and PAUSED. Its transitions are:
- IDLE→PAUSED on a reload with nonzero quanta.
- PAUSED→IDLE on a zero-quanta reload.
- PAUSED→IDLE on the tick that takes the count from 1 to 0.

The gate of each queue is a four-state machine:
- OPEN: no frame in flight.
- SEND: a frame is in flight and no pause is pending.
- DRAIN: a frame is in flight and a pause is pending.
- HOLD: the queue is blocked.

Its transitions are:
- OPEN→SEND on a multi-beat start-of-packet without pause.
- OPEN→DRAIN on a multi-beat start-of-packet with pause.
- OPEN→HOLD on pause with no multi-beat start.
- SEND→DRAIN on pause before end-of-packet.
- DRAIN→SEND when the pause drops before end-of-packet.
- SEND or DRAIN→HOLD at end-of-packet while paused.
- SEND or DRAIN→OPEN at end-of-packet while not paused.
- HOLD→OPEN when the pause drops.

Top module: `pfc_pause_ctrl`

## Requirements
- R1: A strobe whose enable bit n is 1 and whose quanta field n is nonzero makes pause_o[n] 1 from the next cycle.
- R2: A strobe whose enable bit n is 1 and whose quanta field n is 0 makes pause_o[n] 0 from the next cycle.
- R3: A loaded class stays paused for exactly its quanta count of ticks. pause_o[n] falls in the cycle after the tick that brings its count to zero.
- R4: A reload replaces the remaining count with the newest quanta value. Earlier remaining time is discarded.
- R5: A class whose enable bit is 0 in a strobe keeps its count and pause flag unchanged, whatever its quanta field holds.
- R6: Each nonzero timer drops by one on every quanta_tick_i, and all classes share that tick. When a reload and a tick fall in the same cycle, the reload wins.
- R7: If pause_o[n] rises while a frame of queue n is in flight (after a start-of-packet without end-of-packet), tx_block_o[n] stays 0 until that frame's end-of-packet cycle. It is 1 from the following cycle.
- R8: If pause_o[n] is 1 while queue n has no frame in flight, tx_block_o[n] is 1 from the next cycle.
- R9: tx_block_o[n] is 0 in the cycle after pause_o[n] is 0.
- R10: A synchronous reset (rst high at a clock edge) clears every timer, pause_o and tx_block_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid_i | input | 1 | One-cycle strobe for a decoded request |
| frame_en_i | input | 8 | Per-class quanta enable |
| frame_quanta_i | input | 128 | Packed quanta, class n at [16n+15:16n] |
| quanta_tick_i | input | 1 | One pulse per pause quantum |
| tx_sop_i | input | 8 | Start-of-packet accepted on queue n |
| tx_eop_i | input | 8 | End-of-packet accepted on queue n |
| pause_o | output | 8 | Per-class pause flag |
| tx_block_o | output | 8 | Per-queue transmit block |

## Verification
The assertions assume several things about the inputs:
- frame_valid_i is a single-cycle pulse.
- The scheduler starts no new frame on a queue while its tx_block_o bit is 1.
- Each start-of-packet on a queue is followed by exactly one end-of-packet before the next start.

The stimulus changes inputs only on falling edges and keeps all pulses one cycle wide. It opens each frame with one start, closes it with one end, and issues starts only on unblocked queues. Ticks arrive in isolated cycles, except in the one case that deliberately pairs a tick with a reload.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic {
        TM_IDLE,
        TM_PAUSED
    } tmr_state_t;

    typedef enum logic [1:0] {
        GT_OPEN,
        GT_SEND,
        GT_DRAIN,
        GT_HOLD
    } gate_state_t;
endpackage

// File: rtl/pfc_frame_split.sv
module pfc_frame_split #(
    parameter int NUM_CLASSES = 8,
    parameter int QUANTA_W    = 16
) (
    input  logic                                  frame_valid_i,
    input  logic [NUM_CLASSES-1:0]                frame_en_i,
    input  logic [NUM_CLASSES*QUANTA_W-1:0]       frame_quanta_i,
    output logic [NUM_CLASSES-1:0]                load_o,
    output logic [NUM_CLASSES-1:0][QUANTA_W-1:0]  quanta_o
);
    for (genvar n = 0; n < NUM_CLASSES; n++) begin : g_cls
        assign load_o[n]   = frame_valid_i & frame_en_i[n];
        assign quanta_o[n] = frame_quanta_i[n*QUANTA_W +: QUANTA_W];
    end
endmodule

// File: rtl/pfc_class_timer.sv
module pfc_class_timer
    import pfc_pkg::*;
#(
    parameter int QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [QUANTA_W-1:0] quanta_i,
    input  logic                tick_i,
    output logic                pause_o
);
    localparam logic [QUANTA_W-1:0] ONE = {{(QUANTA_W-1){1'b0}}, 1'b1};

    tmr_state_t          state_q, state_d;
    logic [QUANTA_W-1:0] count_q, count_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TM_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            TM_IDLE: begin
                if (load_i && quanta_i != '0) begin
                    state_d = TM_PAUSED;
                    count_d = quanta_i;
                end
            end
            TM_PAUSED: begin
                if (load_i) begin
                    count_d = quanta_i;
                    if (quanta_i == '0) state_d = TM_IDLE;
                end else if (tick_i) begin
                    count_d = count_q - ONE;
                    if (count_q == ONE) state_d = TM_IDLE;
                end
            end
            default: begin
                state_d = TM_IDLE;
                count_d = '0;
            end
        endcase
    end

    always_comb pause_o = (state_q == TM_PAUSED);

    p_load_pauses_r1: assert property (@(posedge clk) disable iff (rst)
        load_i && quanta_i != '0 |=> pause_o);
    p_zero_cancels_r2: assert property (@(posedge clk) disable iff (rst)
        load_i && quanta_i == '0 |=> !pause_o);
    p_expire_r3: assert property (@(posedge clk) disable iff (rst)
        !load_i && tick_i && count_q == ONE |=> !pause_o);
    p_reload_latest_r4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> count_q == $past(quanta_i));
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load_i && !tick_i |=> $stable(count_q) && $stable(pause_o));
    p_tick_dec_r6: assert property (@(posedge clk) disable iff (rst)
        !load_i && tick_i && count_q != '0 |=> count_q == $past(count_q) - ONE);
endmodule

// File: rtl/pfc_tx_gate.sv
module pfc_tx_gate
    import pfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pause_i,
    input  logic sop_i,
    input  logic eop_i,
    output logic block_o
);
    gate_state_t state_q, state_d;
    logic        starts_long;

    always_comb starts_long = sop_i && !eop_i;

    always_ff @(posedge clk) begin
        if (rst) state_q <= GT_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_OPEN: begin
                if (starts_long) state_d = pause_i ? GT_DRAIN : GT_SEND;
                else if (pause_i) state_d = GT_HOLD;
            end
            GT_SEND: begin
                if (eop_i)        state_d = pause_i ? GT_HOLD : GT_OPEN;
                else if (pause_i) state_d = GT_DRAIN;
            end
            GT_DRAIN: begin
                if (eop_i)         state_d = pause_i ? GT_HOLD : GT_OPEN;
                else if (!pause_i) state_d = GT_SEND;
            end
            GT_HOLD: begin
                if (!pause_i) state_d = GT_OPEN;
            end
            default: state_d = GT_OPEN;
        endcase
    end

    always_comb block_o = (state_q == GT_HOLD);

    p_finish_frame_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == GT_SEND || state_q == GT_DRAIN) && !eop_i |=> !block_o);
    p_idle_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        state_q == GT_OPEN && pause_i && !starts_long |=> block_o);
    p_resume_r9: assert property (@(posedge clk) disable iff (rst)
        !pause_i |=> !block_o);
endmodule

// File: rtl/pfc_pause_ctrl.sv
module pfc_pause_ctrl #(
    parameter int NUM_CLASSES = 8,
    parameter int QUANTA_W    = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            frame_valid_i,
    input  logic [NUM_CLASSES-1:0]          frame_en_i,
    input  logic [NUM_CLASSES*QUANTA_W-1:0] frame_quanta_i,
    input  logic                            quanta_tick_i,
    input  logic [NUM_CLASSES-1:0]          tx_sop_i,
    input  logic [NUM_CLASSES-1:0]          tx_eop_i,
    output logic [NUM_CLASSES-1:0]          pause_o,
    output logic [NUM_CLASSES-1:0]          tx_block_o
);
    logic [NUM_CLASSES-1:0]               load;
    logic [NUM_CLASSES-1:0][QUANTA_W-1:0] quanta;

    pfc_frame_split #(
        .NUM_CLASSES(NUM_CLASSES),
        .QUANTA_W   (QUANTA_W)
    ) u_split (
        .frame_valid_i (frame_valid_i),
        .frame_en_i    (frame_en_i),
        .frame_quanta_i(frame_quanta_i),
        .load_o        (load),
        .quanta_o      (quanta)
    );

    for (genvar n = 0; n < NUM_CLASSES; n++) begin : g_class
        pfc_class_timer #(.QUANTA_W(QUANTA_W)) u_timer (
            .clk     (clk),
            .rst     (rst),
            .load_i  (load[n]),
            .quanta_i(quanta[n]),
            .tick_i  (quanta_tick_i),
            .pause_o (pause_o[n])
        );
        pfc_tx_gate u_gate (
            .clk    (clk),
            .rst    (rst),
            .pause_i(pause_o[n]),
            .sop_i  (tx_sop_i[n]),
            .eop_i  (tx_eop_i[n]),
            .block_o(tx_block_o[n])
        );
    end

    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> pause_o == '0 && tx_block_o == '0);
endmodule

// File: tb/pfc_pause_ctrl_test.sv
module pfc_pause_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam int QW = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fv = 1'b0;
    logic [NC-1:0]    fen = '0;
    logic [NC*QW-1:0] fq = '0;
    logic             qt = 1'b0;
    logic [NC-1:0]    sop = '0;
    logic [NC-1:0]    eop = '0;
    logic [NC-1:0]    pause;
    logic [NC-1:0]    block;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfc_pause_ctrl #(.NUM_CLASSES(NC), .QUANTA_W(QW)) uut (
        .clk(clk), .rst(rst), .frame_valid_i(fv), .frame_en_i(fen),
        .frame_quanta_i(fq), .quanta_tick_i(qt), .tx_sop_i(sop),
        .tx_eop_i(eop), .pause_o(pause), .tx_block_o(block)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic send(input logic [NC-1:0] en, input logic [NC*QW-1:0] q, input logic with_tick);
        fv = 1'b1; fen = en; fq = q; qt = with_tick;
        cyc();
        fv = 1'b0; fen = '0; fq = '0; qt = 1'b0;
    endtask

    task automatic tick();
        qt = 1'b1;
        cyc();
        qt = 1'b0;
    endtask

    function automatic logic [NC*QW-1:0] mkq(input int c, input int v);
        logic [NC*QW-1:0] r = '0;
        r[c*QW +: QW] = QW'(v);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NC*QW-1:0] all;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        chk("R10 reset pause", 32'(pause), 0);
        chk("R10 reset block", 32'(block), 0);

        // R1, R3, R5: sweep every class and small quanta values
        for (int c = 0; c < NC; c++) begin
            for (int q = 1; q <= 4; q++) begin
                send(NC'(1) << c, mkq(c, q), 1'b0);
                chk("R1 pause set", 32'(pause), 32'(NC'(1) << c));
                for (int k = 1; k <= q; k++) begin
                    tick();
                    chk("R3 expiry count", 32'(pause[c]), 32'(k < q));
                end
                cyc(); cyc();
                chk("R9 block cleared", 32'(block), 0);
            end
        end

        // R6: shared tick, class c loaded with c+1
        all = '0;
        for (int c = 0; c < NC; c++) all[c*QW +: QW] = QW'(c + 1);
        send('1, all, 1'b0);
        chk("R6 all paused", 32'(pause), 32'hFF);
        for (int k = 1; k <= NC; k++) begin
            tick();
            chk("R6 shared tick", 32'(pause), 32'((8'hFF << k) & 8'hFF));
        end
        cyc(); cyc();

        // R6: reload wins over same-cycle tick
        send(NC'(1) << 4, mkq(4, 3), 1'b1);
        tick(); tick();
        chk("R6 reload beats tick", 32'(pause[4]), 1);
        tick();
        chk("R6 reload beats tick end", 32'(pause[4]), 0);
        cyc(); cyc();

        // R2: zero quanta cancels at once
        send(NC'(1) << 3, mkq(3, 50), 1'b0);
        chk("R2 pre", 32'(pause[3]), 1);
        send(NC'(1) << 3, mkq(3, 0), 1'b0);
        chk("R2 zero cancels", 32'(pause[3]), 0);
        cyc(); cyc();

        // R4: reload discards remaining time
        send(NC'(1) << 2, mkq(2, 10), 1'b0);
        tick(); tick(); tick();
        send(NC'(1) << 2, mkq(2, 2), 1'b0);
        tick();
        chk("R4 reload mid", 32'(pause[2]), 1);
        tick();
        chk("R4 reload end", 32'(pause[2]), 0);
        cyc(); cyc();

        // R5: disabled class ignores its quanta field
        send(NC'(1) << 1, mkq(1, 5), 1'b0);
        send(8'hFD, mkq(1, 0), 1'b0);
        chk("R5 unchanged pause", 32'(pause[1]), 1);
        for (int k = 1; k <= 4; k++) tick();
        chk("R5 timer kept", 32'(pause[1]), 1);
        tick();
        chk("R5 timer kept end", 32'(pause[1]), 0);
        cyc(); cyc();

        // R7: frame in flight finishes before block
        sop[5] = 1'b1; cyc(); sop[5] = 1'b0;
        send(NC'(1) << 5, mkq(5, 20), 1'b0);
        chk("R7 pause up", 32'(pause[5]), 1);
        cyc();
        chk("R7 no block mid-frame", 32'(block[5]), 0);
        cyc();
        chk("R7 no block mid-frame 2", 32'(block[5]), 0);
        eop[5] = 1'b1; cyc(); eop[5] = 1'b0;
        chk("R7 block after eop", 32'(block[5]), 1);
        send(NC'(1) << 5, mkq(5, 0), 1'b0);
        cyc();
        chk("R9 unblock after cancel", 32'(block[5]), 0);

        // R8, R9: idle queue blocks next cycle, resumes after expiry
        send(NC'(1) << 6, mkq(6, 2), 1'b0);
        chk("R8 block not yet", 32'(block[6]), 0);
        cyc();
        chk("R8 idle block", 32'(block[6]), 1);
        tick(); tick();
        chk("R9 pause fell", 32'(pause[6]), 0);
        chk("R9 block one more cycle", 32'(block[6]), 1);
        cyc();
        chk("R9 resume", 32'(block[6]), 0);

        // R10: reset mid-pause
        send('1, all, 1'b0);
        cyc();
        rst = 1'b1; cyc(); rst = 1'b0;
        chk("R10 reset pause", 32'(pause), 0);
        chk("R10 reset block", 32'(block), 0);
        tick();
        chk("R10 timers cleared", 32'(pause), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule